// File: doc/BRIEF.md
# Cache Tag Store with Hit Comparator

This block is the tag side of a direct-mapped cache. It has one entry per index. Each entry holds a tag, a valid flag and a dirty flag. On every rising clock edge it samples the set index and the incoming tag. One cycle later it reports two results:

- a hit, which needs the entry to be valid and its stored tag to equal the incoming tag;
- the entry's dirty flag, so the cache controller knows whether a victim line must be written back.

A write strobe loads a new tag, valid flag and dirty flag into the indexed entry. A clear strobe invalidates every entry at one clock edge. An asynchronous reset does the same. Both result outputs are tri-stated by an output enable, so several tag stores can share the result lines.

The production configuration uses a 14-bit index (16K entries) and a 12-bit tag. The parameter defaults are smaller so that a default elaboration stays cheap.

Top module: `tag_match_store`

## Requirements
- R1: While `rst` is high, and after it is released, `hitOut` and `dirtyOut` read 0 and every entry is invalid.
- R2: The result for the `idxIn`/`tagIn` pair sampled at a rising edge appears on `hitOut`/`dirtyOut` after that edge and holds for the whole following cycle.
- R3: `hitOut` is 1 only when the indexed entry is valid and its stored tag equals `tagIn`. Otherwise it is 0.
- R4: An entry whose valid flag is 0 never produces a hit, even when its stored tag equals `tagIn`.
- R5: With `wrEn` = 1 at a rising edge, `tagIn`, `validIn` and `dirtyIn` are stored into the entry selected by `idxIn`. Other entries are unchanged.
- R6: `dirtyOut` reports the stored dirty flag of the indexed entry.
- R7: With `clearAll` = 1 at a rising edge, every entry becomes invalid with dirty flag 0, in that single edge.
- R8: A lookup sampled at the same edge as a write to the same index reports the entry's contents from before the write. The new contents are seen from the next lookup on.
- R9: When `clearAll` and `wrEn` are both 1 at one edge, the written entry takes the written values and all other entries are cleared.
- R10: With `outEn` = 0, `hitOut` and `dirtyOut` are high-impedance. With `outEn` = 1, they are driven.
- R11: Raising `rst` between clock edges forces `hitOut` and `dirtyOut` to 0 at once and invalidates all entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| idxIn | input | IDX_W | Set index of the lookup or write |
| tagIn | input | TAG_W | Tag to compare with, or to store |
| wrEn | input | 1 | Store tag and flags into the indexed entry |
| validIn | input | 1 | Valid flag to store |
| dirtyIn | input | 1 | Dirty flag to store |
| clearAll | input | 1 | Invalidate every entry |
| outEn | input | 1 | Drive results when 1, high-impedance when 0 |
| hitOut | output | 1 | Registered hit result |
| dirtyOut | output | 1 | Registered dirty flag of the indexed entry |

## Verification
Three operations can land on one edge: a lookup, a write to the same index, and a whole-store clear. The bench provokes each pairing on purpose. It writes to an index while looking that index up, and it raises the clear together with a write. It judges the results with a behavioural model. The model computes the lookup from its contents before the edge, then applies the clear, then the write. It compares both outputs every cycle, so a write leaking into the same-cycle result, or a clear wiping the fresh entry, shows as a mismatch.

// File: rtl/tag_match_pkg.sv
package tag_match_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic storeEn;   // write tag and flags at index
    logic wipeAll;   // invalidate the whole store
  } ctrlStrobe_t;

endpackage

// File: rtl/tag_match_ctrl.sv
module tag_match_ctrl
  import tag_match_pkg::*;
(
  input  logic        wrEn,
  input  logic        clearAll,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe.storeEn = wrEn;
    strobe.wipeAll = clearAll;
  end

endmodule

// File: rtl/tag_match_dp.sv
module tag_match_dp
  import tag_match_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      strobe,
  input  logic [IDX_W-1:0] idxIn,
  input  logic [TAG_W-1:0] tagIn,
  input  logic             validIn,
  input  logic             dirtyIn,
  output logic             hitQ,
  output logic             dirtyQ
);

  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] tagMem [DEPTH];
  logic [DEPTH-1:0] validVec;
  logic [DEPTH-1:0] dirtyVec;
  logic             tagEq;
  logic             hitNext;

  // Tag array: no reset, only the flags need clearing
  always_ff @(posedge clk) begin
    if (strobe.storeEn) tagMem[idxIn] <= tagIn;
  end

  // Status flags: clear first, then the write wins for its own entry
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      validVec <= '0;
      dirtyVec <= '0;
    end else begin
      if (strobe.wipeAll) begin
        validVec <= '0;
        dirtyVec <= '0;
      end
      if (strobe.storeEn) begin
        validVec[idxIn] <= validIn;
        dirtyVec[idxIn] <= dirtyIn;
      end
    end
  end

  assign tagEq   = (tagMem[idxIn] == tagIn);
  assign hitNext = validVec[idxIn] & tagEq;

  // Registered lookup reads the contents before this edge's update
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      hitQ   <= 1'b0;
      dirtyQ <= 1'b0;
    end else begin
      hitQ   <= hitNext;
      dirtyQ <= dirtyVec[idxIn];
    end
  end

  // R4
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    hitQ |-> $past(validVec[idxIn]));

  // R6
  dirty_follows_store_chk: assert property (@(posedge clk) disable iff (rst)
    dirtyQ == $past(dirtyVec[idxIn]));

  // R5
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.storeEn |=> (validVec[$past(idxIn)] == $past(validIn))
                       && (dirtyVec[$past(idxIn)] == $past(dirtyIn)));

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.wipeAll && !strobe.storeEn) |=> (validVec == '0) && (dirtyVec == '0));

  // R9
  clear_keeps_write_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.wipeAll && strobe.storeEn) |=> ($countones(validVec) <= 1));

endmodule

// File: rtl/tag_match_store.sv
module tag_match_store
  import tag_match_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idxIn,
  input  logic [TAG_W-1:0] tagIn,
  input  logic             wrEn,
  input  logic             validIn,
  input  logic             dirtyIn,
  input  logic             clearAll,
  input  logic             outEn,
  output logic             hitOut,
  output logic             dirtyOut
);

  ctrlStrobe_t strobe;
  logic        hitQ;
  logic        dirtyQ;

  tag_match_ctrl u_ctrl (
    .wrEn     (wrEn),
    .clearAll (clearAll),
    .strobe   (strobe)
  );

  tag_match_dp #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .idxIn   (idxIn),
    .tagIn   (tagIn),
    .validIn (validIn),
    .dirtyIn (dirtyIn),
    .hitQ    (hitQ),
    .dirtyQ  (dirtyQ)
  );

  assign hitOut   = outEn ? hitQ   : 1'bz;
  assign dirtyOut = outEn ? dirtyQ : 1'bz;

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk)
    $fell(rst) |-> (!hitQ && !dirtyQ));

endmodule

// File: tb/tb_tag_match_store.sv
module tb_tag_match_store;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4;
  localparam int TAG_W = 6;
  localparam int DEPTH = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [IDX_W-1:0] idxIn = '0;
  logic [TAG_W-1:0] tagIn = '0;
  logic             wrEn = 1'b0;
  logic             validIn = 1'b0;
  logic             dirtyIn = 1'b0;
  logic             clearAll = 1'b0;
  logic             outEn = 1'b1;
  logic             hitOut;
  logic             dirtyOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model
  int refTag   [DEPTH];
  bit refValid [DEPTH];
  bit refDirty [DEPTH];
  bit expHit   = 1'b0;
  bit expDirty = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_match_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst(rst), .idxIn(idxIn), .tagIn(tagIn), .wrEn(wrEn),
    .validIn(validIn), .dirtyIn(dirtyIn), .clearAll(clearAll),
    .outEn(outEn), .hitOut(hitOut), .dirtyOut(dirtyOut)
  );

  task automatic modelWipe();
    for (int i = 0; i < DEPTH; i++) begin
      refValid[i] = 1'b0;
      refDirty[i] = 1'b0;
    end
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOuts(input string req);
    if (outEn) begin
      check(req, hitOut, expHit);
      check(req, dirtyOut, expDirty);
    end else begin
      check(req, hitOut, 1'bz);
      check(req, dirtyOut, 1'bz);
    end
  endtask

  // One cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input int idx, input int tag, input bit we, input bit vi,
                     input bit di, input bit clr, input string req);
    idxIn = idx[IDX_W-1:0];
    tagIn = tag[TAG_W-1:0];
    wrEn = we; validIn = vi; dirtyIn = di; clearAll = clr;
    @(posedge clk);
    expHit   = refValid[idx] && (refTag[idx] == tag);
    expDirty = refDirty[idx];
    if (clr) modelWipe();
    if (we) begin
      refTag[idx]   = tag;
      refValid[idx] = vi;
      refDirty[idx] = di;
    end
    @(negedge clk);
    checkOuts(req);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refTag[i] = 0;
    modelWipe();

    // R1: reset state
    repeat (3) @(negedge clk);
    checkOuts("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    checkOuts("R1 after reset");
    for (int i = 0; i < DEPTH; i++) cyc(i, 0, 0, 0, 0, 0, "R1 empty store");

    // R5/R3/R6/R2: fill every entry, then look each up
    for (int i = 0; i < DEPTH; i++) cyc(i, (i * 5 + 3) % 64, 1, 1, i % 2, 0, "R5 write");
    for (int i = 0; i < DEPTH; i++) cyc(i, (i * 5 + 3) % 64, 0, 0, 0, 0, "R3 R6 hit lookup");
    for (int i = 0; i < DEPTH; i++) cyc(i, (i * 5 + 4) % 64, 0, 0, 0, 0, "R3 wrong tag");
    // R2: alternate index each cycle, result trails by one edge
    for (int i = 0; i < 8; i++) cyc(i % 2 ? 2 : 7, i % 2 ? 13 : 38, 0, 0, 0, 0, "R2 timing");

    // R4: stored tag equal but valid written as 0
    cyc(3, 50, 1, 0, 1, 0, "R4 write invalid");
    cyc(3, 50, 0, 0, 0, 0, "R4 no hit on invalid");

    // R8: write and lookup of the same index in one edge
    cyc(5, 60, 1, 1, 1, 0, "R8 same-edge old contents");
    cyc(5, 60, 0, 0, 0, 0, "R8 new contents next");

    // R7: clear invalidates all in one edge
    cyc(0, 0, 0, 0, 0, 1, "R7 clear edge");
    for (int i = 0; i < DEPTH; i++) cyc(i, (i * 5 + 3) % 64, 0, 0, 0, 0, "R7 all invalid");

    // R9: clear together with a write
    for (int i = 0; i < 4; i++) cyc(i, 20 + i, 1, 1, 1, 0, "R9 prefill");
    cyc(9, 33, 1, 1, 1, 1, "R9 clear with write");
    cyc(9, 33, 0, 0, 0, 0, "R9 written entry kept");
    for (int i = 0; i < 4; i++) cyc(i, 20 + i, 0, 0, 0, 0, "R9 others cleared");

    // R10: output enable
    cyc(9, 33, 0, 0, 0, 0, "R10 driven");
    outEn = 1'b0;
    #1;
    checkOuts("R10 high-Z");
    cyc(9, 33, 0, 0, 0, 0, "R10 high-Z lookup");
    outEn = 1'b1;
    #1;
    checkOuts("R10 driven again");

    // R11: asynchronous reset between edges
    cyc(9, 33, 0, 0, 0, 0, "R11 pre");
    #2 rst = 1'b1;
    #1;
    modelWipe();
    expHit = 1'b0; expDirty = 1'b0;
    checkOuts("R11 async reset");
    @(negedge clk);
    rst = 1'b0;
    cyc(9, 33, 0, 0, 0, 0, "R11 entry invalid");
    cyc(9, 33, 0, 0, 0, 0, "R11 entry invalid");

    // Mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 99);
      cyc($urandom_range(0, DEPTH - 1), $urandom_range(0, 7),
          r < 35, $urandom_range(0, 3) != 0, $urandom_range(0, 1),
          r > 96, "R3 mixed traffic");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule